// File: doc/BRIEF.md
# Buffered Down-Counting Event Timer

This block holds two 32-bit down-counters that advance on a shared tick. The tick runs at half the bus clock rate. Neither counter is ever loaded directly. Software writes a count buffer, and the value reaches the live counter only through a manual-update bit in the shared control register, or through an automatic reload when the counter expires.

One channel is the event channel. It raises a one-cycle interrupt each time it expires. It runs either periodically (auto-reload set) or once (auto-reload clear, with the start bit dropping by itself). The other channel is the timekeeping channel. It is meant to run continuously from an all-ones buffer. Software reads its live value through an observation register and inverts it to get a rising count.

Typical use: to get a period of N ticks, program N-1. Pulse manual update to load the counter, then in one write set start, clear manual update and choose the mode.

Top module: `evt_dntimer`

## Requirements
- R1: In periodic mode a counter loaded with buffer value N expires every N+1 ticks, which is 2·(N+1) clock cycles.
- R2: While a channel's manual-update bit is 1, its counter is loaded from its count buffer on every cycle and does not count.
- R3: With the start bit 0 (and manual update 0), the counter holds its value.
- R4: With auto-reload 0, a channel expires once, reloads its buffer value, and its start bit reads back 0 afterwards. The other control bits of that channel keep their values.
- R5: Ticks occur on every second clock. The timekeeping counter drops by one per tick, so over K cycles (K even) the inverse of the observation register at offset 0x40 rises by exactly K/2.
- R6: A count-buffer write while a channel runs leaves the live counter unchanged until the next reload or manual update. A reload in the same cycle as the write uses the old buffer value.
- R7: Register map. Control is at 0x08. Event channel: count buffer at 0x24, compare buffer at 0x28. Timekeeping channel: count buffer at 0x3C. The event-channel field sits at control bits 15:12 (start 12, manual 13, invert 14, auto-reload 15). The timekeeping field sits at bits 22:20 (start 20, manual 21, auto-reload 22). Other control bits and unmapped offsets read 0.
- R8: The interrupt output is high for exactly one cycle per event-channel expiry and is low in the cycle that follows.
- R9: After reset every register, both counters and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register interface |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| tick_irq | output | 1 | One-cycle pulse when the event channel expires |

## Verification
The collision of interest is a software write to the event channel's count buffer in the very cycle that the counter reloads from that buffer. The bench takes the measured interrupt time and times the write so that it lands on the next reload edge. It then expects one more period of the old length, followed by a period of the new length. A second overlap, the one-shot self-clear of a start bit, is checked by reading back the control word. Start must read 0 while the invert bit written in the same word survives.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
  localparam int WORD_W       = 32;
  localparam int EVT_CH       = 2;
  localparam int KEEP_CH      = 4;
  localparam int EVT_FLD_LSB  = 12;
  localparam int KEEP_FLD_LSB = 20;
  localparam int EVT_FLD_W    = 4;
  localparam int KEEP_FLD_W   = 3;
  localparam int F_START      = 0;
  localparam int F_MANUAL     = 1;
  localparam int F_INVERT     = 2;

  typedef logic [WORD_W-1:0] word_t;

  function automatic int cnt_buf_off(input int ch);
    return 12 * ch + 12;
  endfunction

  function automatic int cmp_buf_off(input int ch);
    return 12 * ch + 16;
  endfunction

  localparam int CTRL_OFF = 8;
  localparam int OBS_OFF  = 64;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else if (tick) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_chk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
    end
  endgenerate
endmodule

// File: rtl/dntimer_channel.sv
module dntimer_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             manual,
  input  logic [CNT_W-1:0] cnt_buf,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] rel);
    return (cur == '0) ? rel : cur - 1'b1;
  endfunction

  logic at_zero;
  logic advance;

  assign at_zero = (count == '0);
  assign advance = tick & run & ~manual;
  assign expire  = advance & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (manual) count <= cnt_buf;
    else if (advance) count <= step_down(count, cnt_buf);
  end

  AST_MANUAL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    manual |=> count == $past(cnt_buf)); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !manual) |=> $stable(count)); // R3
  AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(cnt_buf)); // R1
  AST_ONE_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_zero) |=> count == $past(count) - 1'b1); // R5
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import dntimer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  word_t             reg_wdata,
  output word_t             reg_rdata,
  input  word_t             keep_count,
  input  logic              evt_expire,
  input  logic              keep_expire,
  output logic              evt_run,
  output logic              evt_manual,
  output logic              keep_run,
  output logic              keep_manual,
  output word_t             evt_cnt_buf,
  output word_t             keep_cnt_buf
);
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] A_EVT_CNT  = ADDR_W'(cnt_buf_off(EVT_CH));
  localparam logic [ADDR_W-1:0] A_EVT_CMP  = ADDR_W'(cmp_buf_off(EVT_CH));
  localparam logic [ADDR_W-1:0] A_KEEP_CNT = ADDR_W'(cnt_buf_off(KEEP_CH));
  localparam logic [ADDR_W-1:0] A_KEEP_OBS = ADDR_W'(OBS_OFF);

  logic [EVT_FLD_W-1:0]  evt_fld;
  logic [KEEP_FLD_W-1:0] keep_fld;
  word_t                 evt_cmp_buf;
  logic                  wr_ctrl;
  logic                  evt_oneshot_done;
  logic                  keep_oneshot_done;

  assign wr_ctrl           = reg_wr && (reg_addr == A_CTRL);
  assign evt_oneshot_done  = evt_expire && !evt_fld[EVT_FLD_W-1];
  assign keep_oneshot_done = keep_expire && !keep_fld[KEEP_FLD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_fld  <= '0;
      keep_fld <= '0;
    end else if (wr_ctrl) begin
      evt_fld  <= reg_wdata[EVT_FLD_LSB +: EVT_FLD_W];
      keep_fld <= reg_wdata[KEEP_FLD_LSB +: KEEP_FLD_W];
    end else begin
      if (evt_oneshot_done)  evt_fld[F_START]  <= 1'b0;
      if (keep_oneshot_done) keep_fld[F_START] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt_buf  <= '0;
      evt_cmp_buf  <= '0;
      keep_cnt_buf <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_EVT_CNT)  evt_cnt_buf  <= reg_wdata;
      if (reg_addr == A_EVT_CMP)  evt_cmp_buf  <= reg_wdata;
      if (reg_addr == A_KEEP_CNT) keep_cnt_buf <= reg_wdata;
    end
  end

  assign evt_run     = evt_fld[F_START];
  assign evt_manual  = evt_fld[F_MANUAL];
  assign keep_run    = keep_fld[F_START];
  assign keep_manual = keep_fld[F_MANUAL];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[EVT_FLD_LSB +: EVT_FLD_W]   = evt_fld;
        reg_rdata[KEEP_FLD_LSB +: KEEP_FLD_W] = keep_fld;
      end
      A_EVT_CNT:  reg_rdata = evt_cnt_buf;
      A_EVT_CMP:  reg_rdata = evt_cmp_buf;
      A_KEEP_CNT: reg_rdata = keep_cnt_buf;
      A_KEEP_OBS: reg_rdata = keep_count;
      default:    reg_rdata = '0;
    endcase
  end

  AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_oneshot_done && !wr_ctrl) |=> !evt_run); // R4
  AST_ONESHOT_KEEPS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_oneshot_done && !wr_ctrl) |=> $stable(evt_fld[F_INVERT])); // R4
endmodule

// File: rtl/evt_dntimer.sv
module evt_dntimer
  import dntimer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PRESC_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tick_irq
);
  logic  tick;
  logic  evt_run, evt_manual, keep_run, keep_manual;
  logic  evt_expire, keep_expire;
  word_t evt_cnt_buf, keep_cnt_buf;
  word_t evt_count, keep_count;

  tick_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk (clk), .rst_n (rst_n), .tick (tick)
  );

  timer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .keep_count   (keep_count),
    .evt_expire   (evt_expire),
    .keep_expire  (keep_expire),
    .evt_run      (evt_run),
    .evt_manual   (evt_manual),
    .keep_run     (keep_run),
    .keep_manual  (keep_manual),
    .evt_cnt_buf  (evt_cnt_buf),
    .keep_cnt_buf (keep_cnt_buf)
  );

  dntimer_channel #(.CNT_W(WORD_W)) u_evt_ch (
    .clk (clk), .rst_n (rst_n), .tick (tick), .run (evt_run),
    .manual (evt_manual), .cnt_buf (evt_cnt_buf),
    .count (evt_count), .expire (evt_expire)
  );

  dntimer_channel #(.CNT_W(WORD_W)) u_keep_ch (
    .clk (clk), .rst_n (rst_n), .tick (tick), .run (keep_run),
    .manual (keep_manual), .cnt_buf (keep_cnt_buf),
    .count (keep_count), .expire (keep_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_irq <= 1'b0;
    else tick_irq <= evt_expire;
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq); // R8
  AST_IRQ_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_expire |=> tick_irq); // R8
  AST_NO_EXPIRE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_run |-> !evt_expire); // R3
endmodule

// File: tb/evt_dntimer_tb_top.sv
module evt_dntimer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        tick_irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  evt_dntimer dut_i (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .tick_irq (tick_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] evt_ctl(input bit st, input bit man, input bit inv, input bit ar);
    return {16'h0, ar, inv, man, st, 12'h0};
  endfunction

  function automatic logic [31:0] keep_ctl(input bit st, input bit man, input bit ar);
    return {9'h0, ar, man, st, 20'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(output int t, output bit ok);
    ok = 1'b0;
    t = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tick_irq) begin
        t = cyc; ok = 1'b1;
        return;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] a, b, c, d;
    int t0, t1, t2, t3;
    bit ok, ok2;
    int n_irq, lo_ok;
    bit saw0, saw3, inrange;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    peek(8'h08, a); chk(a == 0, "R9 ctrl", a, 0);
    peek(8'h40, a); chk(a == 0, "R9 obs", a, 0);
    peek(8'h24, a); chk(a == 0, "R9 evt buf", a, 0);
    chk(tick_irq == 0, "R9 irq", {31'h0, tick_irq}, 0);

    // R7 register map and readback; R2 manual load
    wr(8'h24, 32'hA5A5_0003);
    wr(8'h28, 32'h1234_5678);
    wr(8'h3C, 32'hDEAD_BEEF);
    wr(8'h08, 32'hFFFF_FFFF);
    peek(8'h08, a); chk(a == 32'h0070_F000, "R7 ctrl fields", a, 32'h0070_F000);
    peek(8'h24, a); chk(a == 32'hA5A5_0003, "R7 evt cnt buf", a, 32'hA5A5_0003);
    peek(8'h28, a); chk(a == 32'h1234_5678, "R7 evt cmp buf", a, 32'h1234_5678);
    peek(8'h3C, a); chk(a == 32'hDEAD_BEEF, "R7 keep cnt buf", a, 32'hDEAD_BEEF);
    peek(8'h2C, a); chk(a == 0, "R7 unmapped", a, 0);
    repeat (5) @(negedge clk);
    peek(8'h40, a); chk(a == 32'hDEAD_BEEF, "R2 manual held load", a, 32'hDEAD_BEEF);
    chk(tick_irq == 0, "R2 no expire under manual", {31'h0, tick_irq}, 0);
    wr(8'h08, 32'h0);
    wr(8'h3C, 32'd5);
    repeat (4) @(negedge clk);
    peek(8'h40, a); chk(a == 32'hDEAD_BEEF, "R6 stopped buffer write no load", a, 32'hDEAD_BEEF);

    // R5 free-running rate
    wr(8'h3C, 32'd1000);
    wr(8'h08, keep_ctl(0, 1, 1));
    wr(8'h08, keep_ctl(1, 0, 1));
    peek(8'h40, a);
    repeat (20) @(negedge clk);
    peek(8'h40, b);
    chk((~b) - (~a) == 10, "R5 inverse rises K/2", (~b) - (~a), 10);
    chk(b < 32'd1000, "R5 counting down", b, 32'd1000);
    // R6 buffer write while running
    peek(8'h40, c);
    wr(8'h3C, 32'd50000);
    repeat (18) @(negedge clk);
    peek(8'h40, d);
    chk((~d) - (~c) == 10, "R6 running buffer write no effect", (~d) - (~c), 10);
    // R3 halt holds
    wr(8'h08, keep_ctl(0, 0, 1));
    peek(8'h40, a);
    repeat (10) @(negedge clk);
    peek(8'h40, b);
    chk(a == b, "R3 halted value holds", b, a);

    // R1 periodic reload on timekeeping channel, small buffer
    wr(8'h3C, 32'd3);
    wr(8'h08, keep_ctl(0, 1, 1));
    wr(8'h08, keep_ctl(1, 0, 1));
    saw0 = 0; saw3 = 0; inrange = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      peek(8'h40, a);
      if (a > 3) inrange = 0;
      if (a == 0) saw0 = 1;
      if (a == 3) saw3 = 1;
    end
    chk(inrange && saw0 && saw3, "R1 keep periodic wrap", {29'h0, inrange, saw0, saw3}, 32'h7);
    // R4 one-shot on timekeeping channel
    wr(8'h08, keep_ctl(0, 1, 0));
    wr(8'h08, keep_ctl(1, 0, 0));
    repeat (30) @(negedge clk);
    peek(8'h08, a); chk(a == 0, "R4 keep start self-clear", a, 0);
    peek(8'h40, a); chk(a == 3, "R4 keep reloaded and stopped", a, 3);

    // R1 / R8 periodic sweep on event channel
    for (int n = 0; n < 8; n++) begin
      wr(8'h24, n);
      wr(8'h08, evt_ctl(0, 1, 0, 0));
      wr(8'h08, evt_ctl(1, 0, 0, 1));
      wait_irq(t0, ok);
      @(negedge clk);
      lo_ok = (tick_irq == 0);
      chk(ok && lo_ok == 1, "R8 one-cycle pulse", {31'h0, tick_irq}, 0);
      wait_irq(t1, ok);
      wait_irq(t2, ok2);
      chk(ok && (t1 - t0) == 2 * (n + 1), "R1 period first", t1 - t0, 2 * (n + 1));
      chk(ok2 && (t2 - t1) == 2 * (n + 1), "R1 period second", t2 - t1, 2 * (n + 1));
      wr(8'h08, 32'h0);
    end

    // R4 one-shot on event channel, invert bit kept
    wr(8'h24, 32'd4);
    wr(8'h08, evt_ctl(0, 1, 1, 0));
    wr(8'h08, evt_ctl(1, 0, 1, 0));
    n_irq = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick_irq) n_irq++;
    end
    chk(n_irq == 1, "R4 single expiry", n_irq, 1);
    peek(8'h08, a); chk(a == 32'h0000_4000, "R4 start cleared invert kept", a, 32'h0000_4000);

    // R6 collision: buffer write on the reload edge
    wr(8'h24, 32'd5);
    wr(8'h08, evt_ctl(0, 1, 0, 0));
    wr(8'h08, evt_ctl(1, 0, 0, 1));
    wait_irq(t0, ok);
    repeat (11) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 32'd2;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(tick_irq == 1, "R6 expiry on collision edge", {31'h0, tick_irq}, 1);
    wait_irq(t2, ok);
    wait_irq(t3, ok2);
    chk(ok && (t2 - t0) == 24, "R6 old value used at collision", t2 - t0, 24);
    chk(ok2 && (t3 - t2) == 6, "R6 new value after next reload", t3 - t2, 6);
    wr(8'h08, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule